// File: doc/BRIEF.md
# Cascadable Four-Channel Reload Timer

This block holds four 16-bit up-counters. Each counter has a reload register, a control register and the live count. A counter advances in one of two ways. In timed mode it counts cycles of a base clock divided by one of four ratios. In chained mode it advances only when the timer one position below it wraps. When a counter wraps it takes its reload value again. If its interrupt enable is set, it also gives a one-cycle interrupt pulse on its own output line.

Software reaches the bank through a flat register port addressed in 16-bit halves. Half address `2n` is timer n's count and reload slot, and `2n+1` is its control slot. A wide (32-bit) access at either half of timer n covers both slots at once: the reload/count slot is in the low half and control is in the high half. Reads are combinational from the address. Writes take effect at the rising clock edge where `bus_wr` is high. `NUM_TMR` must be a power of two.

Each channel runs a small state machine with three states:
- `CH_IDLE`: stopped.
- `CH_TIMED`: counting prescaled ticks.
- `CH_CHAINED`: counting overflows from the channel below.

The transitions are:
- start: `CH_IDLE`→`CH_TIMED`, taken when the run bit is set with the chain bit clear.
- chained start: `CH_IDLE`→`CH_CHAINED`, taken when the run bit is set with the chain bit set.
- stop: `CH_TIMED`/`CH_CHAINED`→`CH_IDLE`, taken when the run bit is cleared.
- chain-on: `CH_TIMED`→`CH_CHAINED`, taken when the chain bit is set while running.
- chain-off: `CH_CHAINED`→`CH_TIMED`, taken when the chain bit is cleared while running.

Top module: `cascade_timer_bank`

## Requirements
- R1: Control bits [1:0] pick the base-clock cycles per increment in timed mode: 0→2, 1→128, 2→512, 3→2048.
- R2: A control write that sets run bit 7 while it was clear, with chain bit 2 clear, loads the count from the reload value. That reload value includes one written in the same wide access. The prescaler restarts, so the first increment comes exactly one full period after that edge.
- R3: A control write that clears run bit 7 freezes the count at that same edge, with no increment there. The count then holds and stays readable.
- R4: With run and chain bits set, a timer ignores the prescaler. It increments only in the cycle where the timer directly below wraps. Timer 0 has nothing below it and never advances in chained mode.
- R5: A wrap passes to the next timer only if that timer has both bit 7 and bit 2 set. A chain of wraps ripples through several timers in one clock edge. Timer 3 ends the chain.
- R6: When an increment would take the count past 0xFFFF, the count is set to the reload value at that edge.
- R7: With control bit 6 set, each wrap of timer n drives `irq[n]` high for exactly the one cycle after the wrap edge. Several timers wrapping together each pulse. With bit 6 clear, no pulse appears.
- R8: A write to half address 2n stores the reload value and leaves the running count untouched. A read of that address returns the live count.
- R9: A wide write sets the reload value from bits [15:0] and applies bits [31:16] as a control write. A wide read returns {control, count}.
- R10: The control register keeps bits 0, 1, 2, 6 and 7. All other control bits read back as zero.
- R11: Synchronous active-high `rst` clears every count, reload and control register, and holds `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| bus_addr | input | $clog2(NUM_TMR)+1 | Half address: timer index in upper bits, bit 0 selects control |
| bus_wdata | input | 32 | Write data (16-bit writes use bits [15:0]) |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | NUM_TMR | One-cycle interrupt pulses, one per timer |

## Verification
The bench measures the first increment after a start edge for every prescale ratio. A prescaler that does not restart, or that is off by one, moves that increment by a cycle. It sets up a wrap that ripples through three timers in one edge. A chain that ripples only one stage per cycle shows late counts, and a chain that ignores the successor's run bit keeps counting after that bit is cleared. It also checks that a stop write suppresses the increment due at the same edge. Finally, it checks that a reload write to a running counter leaves the count alone and that control bits outside the kept set read back as zero.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
    localparam int HALF_W = 16;
    localparam int B_CASC = 2;
    localparam int B_IRQ  = 6;
    localparam int B_RUN  = 7;
    localparam logic [HALF_W-1:0] CTRL_KEEP = 16'h00C7;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_TIMED   = 2'd1,
        CH_CHAINED = 2'd2
    } ch_state_e;
endpackage

// File: rtl/ctb_prescaler.sv
module ctb_prescaler #(
    parameter int DIV0 = 2,
    parameter int DIV1 = 128,
    parameter int DIV2 = 512,
    parameter int DIV3 = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PRE_W = $clog2(DIV3);
    localparam logic [PRE_W-1:0] LIM0 = PRE_W'(DIV0 - 1);
    localparam logic [PRE_W-1:0] LIM1 = PRE_W'(DIV1 - 1);
    localparam logic [PRE_W-1:0] LIM2 = PRE_W'(DIV2 - 1);
    localparam logic [PRE_W-1:0] LIM3 = PRE_W'(DIV3 - 1);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        unique case (sel)
            2'd0: lim = LIM0;
            2'd1: lim = LIM1;
            2'd2: lim = LIM2;
            default: lim = LIM3;
        endcase
    end

    assign tick = run && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R1
    AST_NO_TICK_AFTER_RESTART: assert property (@(posedge clk) disable iff (rst) restart |=> !tick); // R2
endmodule

// File: rtl/ctb_channel.sv
module ctb_channel
    import ctb_pkg::*;
#(
    parameter int DIV0 = 2,
    parameter int DIV1 = 128,
    parameter int DIV2 = 512,
    parameter int DIV3 = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [HALF_W-1:0] ctrl_wdata,
    input  logic              reload_we,
    input  logic [HALF_W-1:0] reload_wdata,
    input  logic              chain_in,
    output logic [HALF_W-1:0] count_o,
    output logic [HALF_W-1:0] ctrl_o,
    output logic              ovf_o,
    output logic              irq_o
);
    ch_state_e         state_q, state_nxt;
    logic [HALF_W-1:0] ctrl_q, ctrl_nxt;
    logic [HALF_W-1:0] reload_q, reload_eff;
    logic [HALF_W-1:0] count_q;
    logic              irq_q;
    logic              run_nxt, casc_nxt, start_edge;
    logic              tick, inc, wrap;

    assign ctrl_nxt   = ctrl_we ? (ctrl_wdata & CTRL_KEEP) : ctrl_q;
    assign reload_eff = reload_we ? reload_wdata : reload_q;
    assign run_nxt    = ctrl_nxt[B_RUN];
    assign casc_nxt   = ctrl_nxt[B_CASC];
    assign start_edge = ctrl_we && !ctrl_q[B_RUN] && run_nxt;

    ctb_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) pre_i (
        .clk     (clk),
        .rst     (rst),
        .restart (start_edge),
        .run     (state_q == CH_TIMED),
        .sel     (ctrl_q[1:0]),
        .tick    (tick)
    );

    // next-state: named transitions start, chained start, stop, chain-on, chain-off
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (run_nxt) state_nxt = casc_nxt ? CH_CHAINED : CH_TIMED;
            end
            CH_TIMED: begin
                if (!run_nxt)     state_nxt = CH_IDLE;
                else if (casc_nxt) state_nxt = CH_CHAINED;
            end
            CH_CHAINED: begin
                if (!run_nxt)      state_nxt = CH_IDLE;
                else if (!casc_nxt) state_nxt = CH_TIMED;
            end
            default: state_nxt = CH_IDLE;
        endcase
    end

    assign inc  = (state_q == CH_TIMED && state_nxt == CH_TIMED && tick) ||
                  (state_nxt == CH_CHAINED && chain_in);
    assign wrap = inc && (count_q == '1);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_IDLE;
        else     state_q <= state_nxt;
    end

    // outputs and data registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            count_q  <= '0;
            irq_q    <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_nxt;
            reload_q <= reload_eff;
            irq_q    <= wrap && ctrl_nxt[B_IRQ];
            if (start_edge && !casc_nxt) count_q <= reload_eff;
            else if (wrap)               count_q <= reload_eff;
            else if (inc)                count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;
    assign ctrl_o  = ctrl_q;
    assign ovf_o   = wrap;
    assign irq_o   = irq_q;

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        (start_edge && !casc_nxt) |=> count_o == $past(reload_eff)); // R2
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (state_nxt == CH_IDLE && !(start_edge && !casc_nxt)) |=> $stable(count_o)); // R3
    AST_CHAIN_ONLY: assert property (@(posedge clk) disable iff (rst)
        (state_nxt == CH_CHAINED && !chain_in) |=> $stable(count_o)); // R4
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> count_o == $past(reload_eff)); // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (count_o == '0 && ctrl_o == '0 && !irq_o)); // R11
endmodule

// File: rtl/ctb_bus_port.sv
module ctb_bus_port
    import ctb_pkg::*;
#(
    parameter int NUM_TMR = 4
) (
    input  logic                             bus_wr,
    input  logic                             bus_wide,
    input  logic [$clog2(NUM_TMR):0]         bus_addr,
    input  logic [2*HALF_W-1:0]              bus_wdata,
    input  logic [NUM_TMR-1:0][HALF_W-1:0]   cnt_i,
    input  logic [NUM_TMR-1:0][HALF_W-1:0]   ctrl_i,
    output logic [2*HALF_W-1:0]              rdata_o,
    output logic [NUM_TMR-1:0]               reload_we_o,
    output logic [NUM_TMR-1:0]               ctrl_we_o,
    output logic [HALF_W-1:0]                reload_wd_o,
    output logic [HALF_W-1:0]                ctrl_wd_o
);
    localparam int IDX_W = $clog2(NUM_TMR);

    logic [IDX_W-1:0] idx;
    logic             half_ctl;

    assign idx      = bus_addr[IDX_W:1];
    assign half_ctl = bus_addr[0];

    assign reload_wd_o = bus_wdata[HALF_W-1:0];
    assign ctrl_wd_o   = bus_wide ? bus_wdata[2*HALF_W-1:HALF_W] : bus_wdata[HALF_W-1:0];

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_dec
        logic hit;
        assign hit            = bus_wr && (idx == IDX_W'(n));
        assign reload_we_o[n] = hit && (bus_wide || !half_ctl);
        assign ctrl_we_o[n]   = hit && (bus_wide || half_ctl);
    end

    always_comb begin
        if (bus_wide)      rdata_o = {ctrl_i[idx], cnt_i[idx]};
        else if (half_ctl) rdata_o = {{HALF_W{1'b0}}, ctrl_i[idx]};
        else               rdata_o = {{HALF_W{1'b0}}, cnt_i[idx]};
    end
endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank
    import ctb_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int DIV0 = 2,
    parameter int DIV1 = 128,
    parameter int DIV2 = 512,
    parameter int DIV3 = 2048
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic                       bus_wide,
    input  logic [$clog2(NUM_TMR):0]   bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [NUM_TMR-1:0]         irq
);
    logic [NUM_TMR-1:0][HALF_W-1:0] cnt_w, ctrl_w;
    logic [NUM_TMR-1:0]             reload_we, ctrl_we, ovf, chain;
    logic [HALF_W-1:0]              reload_wd, ctrl_wd;

    ctb_bus_port #(.NUM_TMR(NUM_TMR)) bus_i (
        .bus_wr      (bus_wr),
        .bus_wide    (bus_wide),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cnt_i       (cnt_w),
        .ctrl_i      (ctrl_w),
        .rdata_o     (bus_rdata),
        .reload_we_o (reload_we),
        .ctrl_we_o   (ctrl_we),
        .reload_wd_o (reload_wd),
        .ctrl_wd_o   (ctrl_wd)
    );

    assign chain[0] = 1'b0;

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_ch
        if (n > 0) begin : g_link
            assign chain[n] = ovf[n-1];

            AST_RIPPLE: assert property (@(posedge clk) disable iff (rst)
                (ovf[n-1] && ctrl_w[n][B_RUN] && ctrl_w[n][B_CASC] && !ctrl_we[n])
                |=> (cnt_w[n] == $past(cnt_w[n]) + 1'b1) || ($past(cnt_w[n]) == '1)); // R5
        end

        ctb_channel #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) ch_i (
            .clk          (clk),
            .rst          (rst),
            .ctrl_we      (ctrl_we[n]),
            .ctrl_wdata   (ctrl_wd),
            .reload_we    (reload_we[n]),
            .reload_wdata (reload_wd),
            .chain_in     (chain[n]),
            .count_o      (cnt_w[n]),
            .ctrl_o       (ctrl_w[n]),
            .ovf_o        (ovf[n]),
            .irq_o        (irq[n])
        );
    end
endmodule

// File: tb/cascade_timer_bank_tb_top.sv
`timescale 1ns/100ps
module cascade_timer_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst, bus_wr, bus_wide;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [3:0]  irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    cascade_timer_bank dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_wide = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic w, input logic [31:0] exp);
        bus_addr = a; bus_wide = w;
        #0.1;
        chk(req, bus_rdata, exp);
        bus_wide = 1'b0;
    endtask

    task automatic irq_is(input string req, input logic [3:0] exp);
        #0.1;
        chk(req, {28'h0, irq}, {28'h0, exp});
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset;
        for (int n = 0; n < 4; n++) begin
            rd("R11 count after reset", 3'(2*n), 1'b0, 32'h0);
            rd("R11 ctrl after reset", 3'(2*n+1), 1'b0, 32'h0);
        end
        irq_is("R11 irq after reset", 4'h0);
    endtask

    task automatic t_prescale;
        wr(3'd0, 1'b1, {16'h0080, 16'h1000});
        rd("R2 start loads reload", 3'd0, 1'b0, 32'h1000);
        cyc(1);
        rd("R1 div2 before period", 3'd0, 1'b0, 32'h1000);
        cyc(1);
        rd("R1 div2 first increment", 3'd0, 1'b0, 32'h1001);
        cyc(10);
        rd("R1 div2 twelve cycles", 3'd0, 1'b0, 32'h1006);
        wr(3'd1, 1'b0, 32'h0);
        rd("R3 stop edge blocks increment", 3'd0, 1'b0, 32'h1006);
        for (int s = 1; s < 4; s++) begin
            int div;
            div = (s == 1) ? 128 : (s == 2) ? 512 : 2048;
            wr(3'd1, 1'b0, 32'(8'h80 | s));
            rd("R2 restart reload", 3'd0, 1'b0, 32'h1000);
            cyc(div - 1);
            rd("R1 no increment before period", 3'd0, 1'b0, 32'h1000);
            cyc(1);
            rd("R1 increment at period", 3'd0, 1'b0, 32'h1001);
            wr(3'd1, 1'b0, 32'h0);
        end
    endtask

    task automatic t_stop_reload;
        cyc(20);
        rd("R3 stopped count holds", 3'd0, 1'b0, 32'h1001);
        wr(3'd0, 1'b0, 32'h2222);
        rd("R8 reload write keeps count", 3'd0, 1'b0, 32'h1001);
        wr(3'd1, 1'b0, 32'h0080);
        rd("R8 stored reload used on start", 3'd0, 1'b0, 32'h2222);
        wr(3'd1, 1'b0, 32'h0);
        rd("R3 stop at due edge", 3'd0, 1'b0, 32'h2222);
    endtask

    task automatic t_wrap_irq;
        wr(3'd2, 1'b1, {16'h00C0, 16'hFFFE});
        irq_is("R7 no irq at start", 4'h0);
        cyc(3);
        rd("R6 count before wrap", 3'd2, 1'b0, 32'hFFFF);
        irq_is("R7 no irq before wrap", 4'h0);
        cyc(1);
        rd("R6 reload on wrap", 3'd2, 1'b0, 32'hFFFE);
        irq_is("R7 irq pulse after wrap", 4'b0010);
        cyc(1);
        irq_is("R7 irq single cycle", 4'h0);
        wr(3'd3, 1'b0, 32'h0);
        wr(3'd4, 1'b1, {16'h0080, 16'hFFFF});
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            irq_is("R7 disabled irq stays low", 4'h0);
        end
        rd("R6 reload 0xFFFF wraps to itself", 3'd4, 1'b0, 32'hFFFF);
        wr(3'd5, 1'b0, 32'h0);
    endtask

    task automatic t_cascade;
        wr(3'd2, 1'b1, {16'h0083, 16'hFFFE});
        wr(3'd3, 1'b0, 32'h00C4);
        wr(3'd4, 1'b1, {16'h0083, 16'hFFFF});
        wr(3'd4, 1'b0, 32'h0100);
        wr(3'd5, 1'b0, 32'h00C4);
        wr(3'd6, 1'b1, {16'h0083, 16'h0000});
        wr(3'd7, 1'b0, 32'h0084);
        rd("R4 chained t1 preload", 3'd2, 1'b0, 32'hFFFE);
        rd("R8 t2 reload write kept count", 3'd4, 1'b0, 32'hFFFF);
        wr(3'd0, 1'b1, {16'h0080, 16'hFFFF});
        rd("R9 wide write start uses new reload", 3'd0, 1'b0, 32'hFFFF);
        cyc(2);
        rd("R4 t1 stepped by t0 wrap", 3'd2, 1'b0, 32'hFFFF);
        rd("R4 t2 untouched", 3'd4, 1'b0, 32'hFFFF);
        cyc(1);
        irq_is("R7 no irq mid chain", 4'h0);
        cyc(1);
        rd("R5 t1 wrapped", 3'd2, 1'b0, 32'hFFFE);
        rd("R5 t2 wrapped same edge", 3'd4, 1'b0, 32'h0100);
        rd("R5 t3 stepped same edge", 3'd6, 1'b0, 32'h0001);
        irq_is("R7 two pulses same cycle", 4'b0110);
        cyc(1);
        irq_is("R7 pulses end", 4'h0);
        cyc(3);
        irq_is("R7 t1 pulse only", 4'b0010);
        rd("R4 t2 stepped by t1", 3'd4, 1'b0, 32'h0101);
        rd("R5 t3 unchanged", 3'd6, 1'b0, 32'h0001);
        wr(3'd5, 1'b0, 32'h0004);
        cyc(8);
        rd("R5 t2 not started ignores wraps", 3'd4, 1'b0, 32'h0101);
        rd("R5 t3 not reached", 3'd6, 1'b0, 32'h0001);
        rd("R10 t2 ctrl readback", 3'd5, 1'b0, 32'h0004);
        rd("R4 t1 still chained", 3'd2, 1'b0, 32'hFFFF);
        wr(3'd1, 1'b0, 32'h0084);
        cyc(10);
        rd("R4 t0 chained never advances", 3'd0, 1'b0, 32'hFFFF);
        rd("R4 t1 gets no wraps", 3'd2, 1'b0, 32'hFFFF);
        rd("R9 wide read ctrl:count", 3'd2, 1'b1, 32'h00C4FFFF);
    endtask

    task automatic t_ctrl_mask;
        wr(3'd7, 1'b0, 32'h0000FFFF);
        rd("R10 unused ctrl bits zero", 3'd7, 1'b0, 32'h00C7);
        rd("R9 wide read t3", 3'd6, 1'b1, 32'h00C70001);
    endtask

    task automatic t_reset_midrun;
        wr(3'd1, 1'b0, 32'h0080);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int n = 0; n < 4; n++) begin
            rd("R11 count cleared", 3'(2*n), 1'b0, 32'h0);
            rd("R11 ctrl cleared", 3'(2*n+1), 1'b0, 32'h0);
        end
        irq_is("R11 irq low", 4'h0);
        cyc(5);
        rd("R11 nothing runs after reset", 3'd0, 1'b1, 32'h0);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_wide = 1'b0; bus_addr = '0; bus_wdata = '0;
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_prescale();
        t_stop_reload();
        t_wrap_irq();
        t_cascade();
        t_ctrl_mask();
        t_reset_midrun();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule